// File: doc/BRIEF.md
# Chained multi-limb logical right shifter

This block shifts a big integer of any length right by 0 to 63 bit positions. The integer is fed in as 64-bit limbs over a valid/ready stream, most significant limb first. Each accepted limb yields one shifted output limb one cycle later. The low bits that fall off the bottom of a limb are kept in a 64-bit carry word, already aligned to the top positions. That word is ORed into the next, less significant limb.

A start pulse captures the shift amount and loads the carry word from a carry-in port. The shift amount then stays fixed for the whole sequence. A plain shift uses a zero carry-in, so zeros enter the most significant limb. A carry-out port presents the carry word after the limb flagged as last. Feeding that word into the carry-in of a later sequence joins two shifts into one longer shift. Whole-limb shifts are left to whoever picks the limbs.

Top module: `limb_rshift`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: While start is high, in_ready is 0. The start pulse captures shamt and loads the carry word from cin.
- R3: For an accepted limb x, with shift s and carry word c, the output limb is (x >> s) | c. The carry word then becomes x << (64 - s), which is the low s bits of x placed in the top s positions.
- R4: With cin = 0, the limbs of one sequence form the value V >> s, where V is the input integer. Zeros enter the top of the most significant limb.
- R5: When the output limb flagged last is presented, cout holds the carry word left by that limb, which is the bits shifted out of the whole integer.
- R6: With s = 0, every output limb equals its input limb and cout is 0.
- R7: Changes on shamt while start is low have no effect on the running sequence.
- R8: out_last equals the in_last of the limb the output came from.
- R9: While out_valid is 1 and out_ready is 0, out_data, out_last and out_valid hold their values, and in_ready is 0.
- R10: A limb accepted at a clock edge is presented on the output right after that edge.
- R11: A sequence started with cin set to the cout of an earlier sequence continues that shift. The two sequences together give the same limbs as one shift of the joined integer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence: capture shamt, load carry from cin |
| shamt | input | 6 | Shift amount 0..63 |
| cin | input | 64 | Top-aligned carry word to seed the first limb |
| in_valid | input | 1 | Input limb valid |
| in_ready | output | 1 | Input limb accepted when high with in_valid |
| in_data | input | 64 | Input limb |
| in_last | input | 1 | Marks the least significant limb |
| out_valid | output | 1 | Output limb valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | 64 | Shifted output limb |
| out_last | output | 1 | Output limb is the last one |
| cout | output | 64 | Top-aligned carry word left by the last accepted limb |

## Verification
Every output limb and the carry word sit in one register stage. The result of a limb accepted at an edge is therefore due immediately after that edge. The bench drives inputs at the falling edge, waits for the rising edge, and samples one time unit later. in_ready is combinational, so the bench reads it in the same low phase in which it drives start. Under back-pressure the bench samples the held output over two further edges. It then checks that the pending output leaves and the next limb enters on the single edge where out_ready returns high.

// File: rtl/limb_rshift.sv
module limb_rshift #(
  parameter int LIMB_W = 64,
  localparam int SHW = $clog2(LIMB_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SHW-1:0]    shamt,
  input  logic [LIMB_W-1:0] cin,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LIMB_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LIMB_W-1:0] out_data,
  output logic              out_last,
  output logic [LIMB_W-1:0] cout
);
  logic [SHW-1:0]    sh_q;
  logic [LIMB_W-1:0] carry_q;
  logic [SHW:0]      lsh;
  logic [LIMB_W-1:0] spill;
  logic              take;

  assign in_ready = (!out_valid || out_ready) && !start;
  assign take     = in_valid && in_ready;
  assign lsh      = (SHW+1)'(LIMB_W) - {1'b0, sh_q};
  assign spill    = (sh_q == '0) ? '0 : (in_data << lsh);
  assign cout     = carry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q      <= '0;
      carry_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (start) begin
        sh_q    <= shamt;
        carry_q <= cin;
      end else if (take) begin
        carry_q <= spill;
      end
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= (in_data >> sh_q) | carry_q;
        out_last  <= in_last;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/limb_rshift_chk.sv
module limb_rshift_chk #(
  parameter int LIMB_W = 64,
  localparam int SHW = $clog2(LIMB_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LIMB_W-1:0] out_data,
  input logic              out_last,
  input logic [LIMB_W-1:0] cout,
  input logic [SHW-1:0]    sh_q
);
  p_start_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready);

  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_stall_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_shamt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(sh_q));

  p_zero_cout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && sh_q == '0 |=> cout == '0);
endmodule

bind limb_rshift limb_rshift_chk #(.LIMB_W(LIMB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .cout(cout), .sh_q(sh_q)
);

// File: tb/limb_rshift_bench.sv
module limb_rshift_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic clk = 0, rst_n = 0, start = 0, in_valid = 0, in_last = 0, out_ready = 1;
  logic [5:0] shamt = 0;
  logic [W-1:0] cin = 0, in_data = 0;
  logic in_ready, out_valid, out_last;
  logic [W-1:0] out_data, cout;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limb_rshift u_limb_rshift (
    .clk(clk), .rst_n(rst_n), .start(start), .shamt(shamt), .cin(cin),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .cout(cout)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(logic [5:0] s, logic [W-1:0] c);
    @(negedge clk);
    start = 1; shamt = s; cin = c;
    #1 chk("R2 in_ready low during start", W'(in_ready), 0);
    @(negedge clk);
    start = 0; shamt = $urandom;
  endtask

  // drive one limb, check output right after the accepting edge
  task automatic send(logic [W-1:0] d, logic last, logic [W-1:0] exp);
    @(negedge clk);
    in_valid = 1; in_data = d; in_last = last;
    @(posedge clk); #1;
    chk("R10 out_valid after accept", W'(out_valid), 1);
    chk("R3 R4 output limb", out_data, exp);
    chk("R8 out_last", W'(out_last), W'(last));
    @(negedge clk);
    in_valid = 0; shamt = $urandom; // R7: shamt churn must be ignored
  endtask

  task automatic t_reset;
    chk("R1 out_valid reset", W'(out_valid), 0);
    chk("R1 in_ready reset", W'(in_ready), 1);
  endtask

  // limbs[0] is most significant
  task automatic run_seq(int n, int s, logic [W-1:0] c, logic [W-1:0] limbs[8],
                         output logic [W-1:0] got_cout);
    logic [8*W+W-1:0] v, r;
    v = '0;
    for (int k = 0; k < n; k++) v = (v << W) | (8*W+W)'(limbs[k]);
    v = v | ((8*W+W)'(c) << (n*W - (64 - s) % 64 - ((s == 0) ? W : 0)));
    r = ({v, {W{1'b0}}} >> s) >> 0;
    do_start(6'(s), c);
    for (int k = 0; k < n; k++)
      send(limbs[k], k == n-1, r[W*(n-1-k)+W +: W]);
    got_cout = cout;
    chk("R5 cout after last", cout, r[W-1:0]);
    if (s == 0) chk("R6 zero shift cout", cout, 0);
  endtask

  task automatic t_sweep;
    logic [W-1:0] l[8];
    logic [W-1:0] co;
    for (int s = 0; s < 64; s++) begin
      for (int k = 0; k < 8; k++) l[k] = {$urandom, $urandom};
      run_seq(1 + s % 8, s, '0, l, co);
    end
  endtask

  task automatic t_chain;
    logic [W-1:0] all[8], hi[8], lo[8];
    logic [W-1:0] co, co2;
    logic [4*W-1:0] v, r;
    for (int k = 0; k < 8; k++) begin all[k] = {$urandom, $urandom}; hi[k] = 0; lo[k] = 0; end
    for (int k = 0; k < 2; k++) begin hi[k] = all[k]; lo[k] = all[k+2]; end
    v = {all[0], all[1], all[2], all[3]};
    r = v >> 13;
    do_start(6'd13, '0);
    send(hi[0], 0, r[4*W-1 -: W]);
    send(hi[1], 1, r[3*W-1 -: W]);
    co = cout;
    do_start(6'd13, co);
    send(lo[0], 0, r[2*W-1 -: W]);
    send(lo[1], 1, r[W-1:0]);
    co2 = cout;
    chk("R11 joined cout", co2, all[3] << 51);
  endtask

  task automatic t_backpressure;
    logic [W-1:0] a = 64'hF00D_1234_5678_9ABC, b = 64'h0123_4567_89AB_CDEF;
    do_start(6'd4, '0);
    out_ready = 0;
    @(negedge clk); in_valid = 1; in_data = a; in_last = 0;
    @(posedge clk); #1;
    chk("R10 first limb out", out_data, a >> 4);
    @(negedge clk); in_data = b; in_last = 1;
    #1 chk("R9 in_ready low when stalled", W'(in_ready), 0);
    repeat (2) @(posedge clk); #1;
    chk("R9 out held valid", W'(out_valid), 1);
    chk("R9 out held data", out_data, a >> 4);
    chk("R9 out held last", W'(out_last), 0);
    @(negedge clk); out_ready = 1;
    @(posedge clk); #1;
    chk("R9 next limb after release", out_data, (b >> 4) | (a << 60));
    chk("R8 last after release", W'(out_last), 1);
    chk("R5 cout after release", cout, b << 60);
    @(negedge clk); in_valid = 0;
    @(posedge clk); #1;
    chk("R9 drained", W'(out_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 t_reset();
    t_sweep();
    t_chain();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule